// File: doc/BRIEF.md
# Serial Control Command Interpreter

This block sits behind a serial port's receive shifter and turns each 16-bit control word into an action on an internal register space. The upper byte of a word is the operation code and the lower byte is its operand. The register space is reached indirectly. Two byte-wide pointer registers, one for the high address byte and one for the low address byte, are concatenated into a 16-bit target address. Write commands load one of these pointers or strobe a byte into another destination register. Read commands fetch a byte from the register map at the current target address.

Read results are not returned at once. They wait in a two-entry byte queue until the next frame boundary. At that boundary they are packed into a 16-bit append word, which the output shifter sends at the end of the following frame. The first read of a frame fills the upper byte of the append word and the second read fills the lower byte. A byte with no read behind it is sent as zero. The serial framing allows one command per sample-word period, so a four-word frame carries up to four commands. Frame timing and the register map itself belong to neighbouring logic.

Command words enter on a valid/ready stream. `cmd_ready` is held high at all times, so the interpreter never applies back-pressure: every cycle with `cmd_valid` high transfers one command. A source may keep `cmd_valid` high on consecutive cycles. Read data is fetched combinationally: `rd_data` must reflect `rd_addr` during the cycle in which `rd_req` is high. The frame boundary strobe and all outputs other than `cmd_ready` are plain control and status pins.

Top module: `sctl_cmd_interp`

## Requirements
- R1: A command transfers on every rising edge at which `cmd_valid` is high, because `cmd_ready` is always 1. Bits [15:8] of the command are the operation code and bits [7:0] are the operand.
- R2: Operation code 0x47 loads the operand into the high address pointer. The new value appears on `ptr_hi` in the cycle after the transfer.
- R3: Operation code 0x46 loads the operand into the low address pointer. The new value appears on `ptr_lo` in the cycle after the transfer.
- R4: `reg_addr` and `rd_addr` always equal {`ptr_hi`, `ptr_lo`}. For example, 0x03 and 0x00 give 0x0300.
- R5: Any operation code from 0x40 to 0x4F raises `wr_en` for exactly one cycle, in the cycle after the transfer. In that cycle `wr_sel` carries code bits [3:0] and `wr_data` carries the operand.
- R6: An operation code with bit 7 set is a read. It raises `rd_req` combinationally in its transfer cycle with `rd_addr` at the current target address, provided the read queue has room. The operand of a read has no effect.
- R7: On a rising edge with `frame_strobe` high, `append_word` is loaded. Bits [15:8] take the first read byte of the closing frame and bits [7:0] take the second.
- R8: When the closing frame had no read, the corresponding append byte is 0x00. The read queue is emptied by every frame boundary.
- R9: A third or later read in one frame raises no `rd_req` and leaves the append word of that frame unchanged.
- R10: Operation codes 0x00 to 0x3F and 0x50 to 0x7F have no effect on the pointers, `wr_en` or the queued reads.
- R11: After reset both pointers are 0x00, `append_word` is 0x0000, `wr_en` is 0 and the queue is empty.
- R12: A read transferred in the same cycle as `frame_strobe` belongs to the new frame. It becomes the first byte of the next append word and does not appear in the word loaded at that boundary.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Command word present |
| cmd_ready | output | 1 | Always 1; no back-pressure |
| cmd_word | input | 16 | Command: code [15:8], operand [7:0] |
| frame_strobe | input | 1 | One-cycle pulse at each frame boundary |
| ptr_hi | output | 8 | High address pointer |
| ptr_lo | output | 8 | Low address pointer |
| reg_addr | output | 16 | Target address {ptr_hi, ptr_lo} |
| wr_en | output | 1 | One-cycle register write strobe |
| wr_sel | output | 4 | Destination register of the write |
| wr_data | output | 8 | Write data byte |
| rd_req | output | 1 | Read fetch this cycle |
| rd_addr | output | 16 | Address of the read fetch |
| rd_data | input | 8 | Byte returned by the register map |
| append_word | output | 16 | Read results for the appended field |

## Verification
The stimulus first replays a typical frame: load the high pointer, load the low pointer, issue a read, then move the low pointer. The append word must return exactly that single byte, with a zero low byte. Frames with zero, two and three reads follow. They separate correct byte order and zero fill from queue overflow. A read placed on the frame strobe itself shows whether the boundary clears the queue before or after a new entry is taken. Runs of back-to-back commands, unused codes and the other 0x4X write codes check that only the defined codes touch state, and that read operands are ignored.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int unsigned CMD_W   = 16;
  localparam int unsigned BYTE_W  = CMD_W / 2;
  localparam int unsigned ADDR_W  = 2 * BYTE_W;
  localparam int unsigned SEL_W   = 4;
  localparam int unsigned Q_DEPTH = 2;

  localparam logic [SEL_W-1:0] SEL_PTR_HI = 4'h7;
  localparam logic [SEL_W-1:0] SEL_PTR_LO = 4'h6;
  localparam logic [3:0]       WR_GROUP   = 4'h4;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_WRITE = 2'd1,
    OP_READ  = 2'd2
  } op_kind_e;

  function automatic op_kind_e classify(input logic [BYTE_W-1:0] code);
    if (code[BYTE_W-1])                   return OP_READ;
    if (code[BYTE_W-2:SEL_W] == 3'(WR_GROUP)) return OP_WRITE;
    return OP_NONE;
  endfunction
endpackage

// File: rtl/sctl_decode.sv
module sctl_decode
  import sctl_pkg::*;
(
  input  logic              valid,
  input  logic [CMD_W-1:0]  word,
  output logic              is_wr,
  output logic              is_rd,
  output logic [SEL_W-1:0]  sel,
  output logic [BYTE_W-1:0] operand
);
  op_kind_e kind;

  always_comb begin
    kind    = classify(word[CMD_W-1:BYTE_W]);
    is_wr   = valid && (kind == OP_WRITE);
    is_rd   = valid && (kind == OP_READ);
    sel     = word[BYTE_W+SEL_W-1:BYTE_W];
    operand = word[BYTE_W-1:0];
  end

  always_comb begin
    assert_exclusive_R1: assert (!(is_wr && is_rd));
  end
endmodule

// File: rtl/sctl_ptr_regs.sv
module sctl_ptr_regs
  import sctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_wr,
  input  logic [SEL_W-1:0]  sel,
  input  logic [BYTE_W-1:0] operand,
  output logic [BYTE_W-1:0] hi_q,
  output logic [BYTE_W-1:0] lo_q,
  output logic              wr_en_q,
  output logic [SEL_W-1:0]  wr_sel_q,
  output logic [BYTE_W-1:0] wr_data_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q      <= '0;
      lo_q      <= '0;
      wr_en_q   <= 1'b0;
      wr_sel_q  <= '0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= is_wr;
      if (is_wr) begin
        wr_sel_q  <= sel;
        wr_data_q <= operand;
        if (sel == SEL_PTR_HI) hi_q <= operand;
        if (sel == SEL_PTR_LO) lo_q <= operand;
      end
    end
  end

  assert_hi_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && sel == SEL_PTR_HI) |=> (hi_q == $past(operand)));
  assert_lo_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (is_wr && sel == SEL_PTR_LO) |=> (lo_q == $past(operand)));
  assert_ptr_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !is_wr |=> ($stable(hi_q) && $stable(lo_q)));
endmodule

// File: rtl/sctl_rd_queue.sv
module sctl_rd_queue
  import sctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              is_rd,
  input  logic              boundary,
  input  logic [BYTE_W-1:0] rd_byte,
  output logic              room,
  output logic [CMD_W-1:0]  append_q
);
  localparam int unsigned CNT_W = $clog2(Q_DEPTH + 1);

  logic [CNT_W-1:0]  count_q;
  logic [BYTE_W-1:0] slot_q [Q_DEPTH];
  logic              push;
  logic [CMD_W-1:0]  packed_w;

  assign room = boundary || (count_q < CNT_W'(Q_DEPTH));
  assign push = is_rd && room;

  always_comb begin
    packed_w = '0;
    for (int i = 0; i < Q_DEPTH; i++) begin
      if (count_q > CNT_W'(i))
        packed_w[CMD_W-1-i*BYTE_W -: BYTE_W] = slot_q[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q  <= '0;
      append_q <= '0;
      for (int i = 0; i < Q_DEPTH; i++) slot_q[i] <= '0;
    end else if (boundary) begin
      append_q <= packed_w;
      count_q  <= push ? CNT_W'(1) : '0;
      if (push) slot_q[0] <= rd_byte;
    end else if (push) begin
      for (int i = 0; i < Q_DEPTH; i++)
        if (count_q == CNT_W'(i)) slot_q[i] <= rd_byte;
      count_q <= count_q + CNT_W'(1);
    end
  end

  assert_depth_R9: assert property (@(posedge clk) disable iff (!rst_n)
    count_q <= CNT_W'(Q_DEPTH));
  assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && !is_rd) |=> (count_q == '0));
  assert_new_frame_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (boundary && is_rd) |=> (count_q == CNT_W'(1)));
endmodule

// File: rtl/sctl_cmd_interp.sv
module sctl_cmd_interp
  import sctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [CMD_W-1:0]  cmd_word,
  input  logic              frame_strobe,
  output logic [BYTE_W-1:0] ptr_hi,
  output logic [BYTE_W-1:0] ptr_lo,
  output logic [ADDR_W-1:0] reg_addr,
  output logic              wr_en,
  output logic [SEL_W-1:0]  wr_sel,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [CMD_W-1:0]  append_word
);
  logic              dec_wr, dec_rd, q_room;
  logic [SEL_W-1:0]  dec_sel;
  logic [BYTE_W-1:0] dec_operand;

  assign cmd_ready = 1'b1;

  sctl_decode u_dec (
    .valid   (cmd_valid && cmd_ready),
    .word    (cmd_word),
    .is_wr   (dec_wr),
    .is_rd   (dec_rd),
    .sel     (dec_sel),
    .operand (dec_operand)
  );

  sctl_ptr_regs u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .is_wr     (dec_wr),
    .sel       (dec_sel),
    .operand   (dec_operand),
    .hi_q      (ptr_hi),
    .lo_q      (ptr_lo),
    .wr_en_q   (wr_en),
    .wr_sel_q  (wr_sel),
    .wr_data_q (wr_data)
  );

  sctl_rd_queue u_rq (
    .clk      (clk),
    .rst_n    (rst_n),
    .is_rd    (dec_rd),
    .boundary (frame_strobe),
    .rd_byte  (rd_data),
    .room     (q_room),
    .append_q (append_word)
  );

  assign reg_addr = {ptr_hi, ptr_lo};
  assign rd_addr  = reg_addr;
  assign rd_req   = dec_rd && q_room;

  assert_wr_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_word[15:12] == WR_GROUP)
      |=> (wr_en && wr_sel == $past(cmd_word[11:8]) && wr_data == $past(cmd_word[7:0])));
  assert_no_spurious_wr_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(cmd_valid && cmd_word[15:12] == WR_GROUP) |=> !wr_en);
  assert_rd_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req |-> (cmd_valid && cmd_word[15]));
endmodule

// File: tb/sim_sctl_cmd_interp.sv
module sim_sctl_cmd_interp;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic [15:0] cmd_word = '0;
  logic        frame_strobe = 1'b0;
  logic [7:0]  ptr_hi, ptr_lo, wr_data, rd_data;
  logic [15:0] reg_addr, rd_addr, append_word;
  logic        wr_en, rd_req;
  logic [3:0]  wr_sel;

  int checks = 0;
  int errors = 0;

  // model state
  logic [7:0]  m_hi = 0, m_lo = 0, m_wdata = 0;
  logic [3:0]  m_wsel = 0;
  logic        m_wen = 0;
  logic [15:0] m_app = 0;
  logic [7:0]  m_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [7:0] mem(input logic [15:0] a);
    return a[15:8] ^ {a[3:0], a[7:4]} ^ 8'h5A;
  endfunction
  assign rd_data = mem(rd_addr);

  sctl_cmd_interp u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_word(cmd_word), .frame_strobe(frame_strobe), .ptr_hi(ptr_hi),
    .ptr_lo(ptr_lo), .reg_addr(reg_addr), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .rd_req(rd_req), .rd_addr(rd_addr), .rd_data(rd_data),
    .append_word(append_word)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic check_state();
    chk(ptr_hi == m_hi, "R2 ptr_hi", 32'(ptr_hi), 32'(m_hi));
    chk(ptr_lo == m_lo, "R3 ptr_lo", 32'(ptr_lo), 32'(m_lo));
    chk(reg_addr == {m_hi, m_lo}, "R4 reg_addr", 32'(reg_addr), 32'({m_hi, m_lo}));
    chk(wr_en == m_wen, "R5 R10 wr_en", 32'(wr_en), 32'(m_wen));
    if (m_wen) begin
      chk(wr_sel == m_wsel, "R5 wr_sel", 32'(wr_sel), 32'(m_wsel));
      chk(wr_data == m_wdata, "R5 wr_data", 32'(wr_data), 32'(m_wdata));
    end
    chk(append_word == m_app, "R7 R8 append_word", 32'(append_word), 32'(m_app));
  endtask

  // one clock: drive at negedge, check combinational read, model edge, check regs
  task automatic step(input bit v, input logic [15:0] w, input bit fs);
    bit exp_req;
    logic [7:0] op;
    @(negedge clk);
    cmd_valid = v; cmd_word = w; frame_strobe = fs;
    #1;
    op = w[15:8];
    exp_req = v && op[7] && (fs || m_q.size() < 2);
    chk(cmd_ready == 1'b1, "R1 cmd_ready", 32'(cmd_ready), 32'd1);
    chk(rd_req == exp_req, "R6 R9 rd_req", 32'(rd_req), 32'(exp_req));
    chk(rd_addr == {m_hi, m_lo}, "R4 rd_addr", 32'(rd_addr), 32'({m_hi, m_lo}));
    @(posedge clk);
    m_wen = 1'b0;
    if (fs) begin
      m_app = {(m_q.size() > 0) ? m_q[0] : 8'h00, (m_q.size() > 1) ? m_q[1] : 8'h00};
      m_q.delete();
    end
    if (v) begin
      if (op[7]) begin
        if (m_q.size() < 2) m_q.push_back(mem({m_hi, m_lo}));
      end else if (op[7:4] == 4'h4) begin
        m_wen = 1'b1; m_wsel = op[3:0]; m_wdata = w[7:0];
        if (op[3:0] == 4'h7) m_hi = w[7:0];
        if (op[3:0] == 4'h6) m_lo = w[7:0];
      end
    end
    @(negedge clk);
    cmd_valid = 1'b0; frame_strobe = 1'b0;
    #1;
    check_state();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(1'b0, 16'h0000, 1'b0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1;
    // R11 reset state
    chk(ptr_hi == 0 && ptr_lo == 0, "R11 pointers", 32'(reg_addr), 32'd0);
    chk(append_word == 0, "R11 append", 32'(append_word), 32'd0);
    chk(wr_en == 0, "R11 wr_en", 32'(wr_en), 32'd0);
    rst_n = 1'b1;
    idle(2);

    // typical frame: hi=03, lo=00, read (operand ignored), lo=03
    step(1, 16'h4703, 0);
    step(1, 16'h4600, 0);
    step(1, 16'h80A5, 0);
    step(1, 16'h4603, 0);
    step(0, 16'h0000, 1);          // R7/R8 one read, low byte zero
    // zero reads -> append 0000
    idle(1);
    step(0, 16'h0000, 1);          // R8
    // two reads, back to back, at different addresses
    step(1, 16'h9F00, 0);
    step(1, 16'h4611, 0);
    step(1, 16'hFFFF, 0);
    step(0, 16'h0000, 1);          // R7 byte order
    // three reads: third dropped (R9)
    step(1, 16'h8000, 0);
    step(1, 16'h4722, 0);
    step(1, 16'h8100, 0);
    step(1, 16'h4733, 0);
    step(1, 16'h8000, 0);
    step(0, 16'h0000, 1);
    // read on the frame strobe itself (R12), after one read in closing frame
    step(1, 16'h8000, 0);
    step(1, 16'h4644, 0);
    step(1, 16'hC000, 1);
    step(1, 16'h8000, 0);
    step(0, 16'h0000, 1);
    // unrecognised codes (R10) and other write destinations (R5)
    step(1, 16'h00FF, 0);
    step(1, 16'h3F12, 0);
    step(1, 16'h5034, 0);
    step(1, 16'h7F56, 0);
    step(1, 16'h4A9C, 0);
    step(1, 16'h4001, 0);
    step(1, 16'h4F7E, 0);
    step(0, 16'h0000, 1);          // nothing queued -> 0000
    // back-to-back pointer writes (R2 R3)
    step(1, 16'h47AB, 0);
    step(1, 16'h46CD, 0);
    step(1, 16'h8800, 0);
    step(0, 16'h0000, 1);
    idle(2);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule